// File: doc/BRIEF.md
# Drive Fault Supervisor with Priority Lockout

This block watches the comparators around a high-side switch and its freewheel clamp switch in a peak-and-hold solenoid driver. It filters each comparator, turns confirmed faults into latched report bits and an active-low alarm, and issues protection commands to the gate/clamp sequencer. The first destructive fault seen since the last clear freezes the report, so the host reads the original cause and not the faults that follow from it.

A drive cycle is the interval in which both `en_in` and `ctl_in` are high. Protection latches release only when a new cycle starts. The report bits and the alarm clear only on the serial-port clear strobe. The report is copied into the serial capture register only while `cs_n` is high, so a frame in progress always reads a stable word.

No data stream passes through the block. Every pin is a plain level or a one-clock strobe, so there is no valid/ready handshake and no back-pressure.

Top module: `drive_fault_mgr`

## Requirements
- R1: The report word places overcurrent at bit 0, open load at bit 1, clamp-switch saturation at bit 2, gate-switch saturation at bit 3 and overvoltage at bit 4.
- R2: An overcurrent is confirmed only after `oc_raw` has been high on OC_FILT consecutive clock edges; a shorter pulse leaves no trace. Confirmation works whatever the state of `en_in` and `ctl_in`. The report bit and the alarm appear one edge after confirmation.
- R3: A confirmed overcurrent always drives `fault_n` low. During a drive cycle it also latches `force_all_off`.
- R4: Gate saturation counts only while `gate_on` is high in a drive cycle, and clamp saturation only while `clamp_on` is high in a drive cycle. Each needs SAT_FILT consecutive qualified edges. Each then latches `force_all_off`, sets its report bit and drives `fault_n` low.
- R5: Once a priority fault has been recorded, no further report bits are added until the next clear strobe. The priority faults are overcurrent, both saturations, and overvoltage with protection enabled.
- R6: When a drive cycle ends and `loop_toggle` was never high during it, the open-load bit is set one edge later and `fault_n` is left unchanged.
- R7: With `ov_protect_en` low, `ov_raw` sets the overvoltage bit on the next edge. It leaves `fault_n` and both force outputs untouched.
- R8: With `ov_protect_en` high during a drive cycle, `ov_raw` latches `force_gate_off_clamp_on`, drives `fault_n` low and counts as a priority fault.
- R9: Protection latches clear on the edge that sees the drive cycle start. A clear strobe does not release them.
- R10: The report bits and the alarm clear on the clear strobe `cs_rise`. The start or end of a drive cycle does not clear them.
- R11: While `cs_n` is low, `fault_vec` holds its value.
- R12: A fault present on the same edge as the clear strobe stays recorded after the clear.
- R13: After reset, `fault_vec` is zero, `fault_n` is high and both force outputs are low.
- R14: `force_all_off` takes precedence: the two force outputs are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| oc_raw | input | 1 | Raw overcurrent comparator |
| gate_sat_raw | input | 1 | Raw gate-switch saturation comparator |
| clamp_sat_raw | input | 1 | Raw clamp-switch saturation comparator |
| ov_raw | input | 1 | Raw supply overvoltage comparator |
| en_in | input | 1 | Enable input |
| ctl_in | input | 1 | Control input |
| gate_on | input | 1 | Gate drive currently on |
| clamp_on | input | 1 | Clamp drive currently on |
| loop_toggle | input | 1 | Current-loop state changed this clock |
| ov_protect_en | input | 1 | Overvoltage acts as a protecting fault |
| cs_n | input | 1 | Serial chip select, low during a frame |
| cs_rise | input | 1 | One-clock clear strobe at end of frame |
| fault_vec | output | 5 | Report word for serial capture |
| fault_n | output | 1 | Active-low alarm |
| force_all_off | output | 1 | Command: both drives off |
| force_gate_off_clamp_on | output | 1 | Command: gate off, clamp on |

## Verification
Overcurrent is driven both with the cycle idle and inside a cycle. This separates the unconditional report and alarm from the cycle-gated shutdown. Pulses one edge short of the filter length are checked against pulses of exactly the filter length. Each saturation comparator is held high first with its qualifier low and then with it high, which shows the gating. Overvoltage is applied with protection off and on, and is then followed by an overcurrent to expose the lockout and the precedence of the shutdown command. Cycles that end with and without a loop toggle tell a real open load from a healthy one. Clear strobes are issued while a fault is still present and while `cs_n` is low, to check that the clear keeps a same-edge fault and that the capture freezes.

// File: rtl/drive_fault_pkg.sv
package drive_fault_pkg;
  localparam int NFLT     = 5;
  localparam int BIT_OC   = 0;
  localparam int BIT_OPEN = 1;
  localparam int BIT_CSAT = 2;
  localparam int BIT_GSAT = 3;
  localparam int BIT_OV   = 4;
  typedef logic [NFLT-1:0] fault_word_t;
endpackage

// File: rtl/fault_persist_filter.sv
module fault_persist_filter #(
  parameter int LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic hit
);
  localparam int CW = $clog2(LEN + 1);
  localparam logic [CW-1:0] FULL = CW'(LEN);

  logic [CW-1:0] cnt;

  // Any deassertion of the raw input restarts the count.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (!raw)        cnt <= '0;
    else if (cnt != FULL) cnt <= cnt + 1'b1;
  end

  assign hit = (cnt == FULL);
endmodule

// File: rtl/cycle_tracker.sv
module cycle_tracker (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic loop_toggle,
  output logic cycle_start,
  output logic open_evt
);
  logic active_q;
  logic loop_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q  <= 1'b0;
      loop_seen <= 1'b0;
    end else begin
      active_q <= active;
      if (cycle_start)                 loop_seen <= loop_toggle;
      else if (active && loop_toggle)  loop_seen <= 1'b1;
    end
  end

  assign cycle_start = active & ~active_q;
  assign open_evt    = active_q & ~active & ~loop_seen;
endmodule

// File: rtl/fault_report_latch.sv
module fault_report_latch
  import drive_fault_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  fault_word_t evt,
  input  logic        prio_evt,
  input  logic        flag_evt,
  input  logic        clr,
  input  logic        cs_n,
  output fault_word_t cap_vec,
  output logic        flag
);
  fault_word_t pend, pend_nx, base_pend;
  logic        lock, lock_nx, base_lock, flag_nx;

  always_comb begin
    base_pend = clr ? '0 : pend;
    base_lock = clr ? 1'b0 : lock;
    // Events on the clearing edge are merged after the clear.
    pend_nx   = base_pend | (base_lock ? '0 : evt);
    lock_nx   = base_lock | prio_evt;
    flag_nx   = (clr ? 1'b0 : flag) | flag_evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend    <= '0;
      lock    <= 1'b0;
      flag    <= 1'b0;
      cap_vec <= '0;
    end else begin
      pend <= pend_nx;
      lock <= lock_nx;
      flag <= flag_nx;
      if (cs_n) cap_vec <= pend_nx;
    end
  end
endmodule

// File: rtl/drive_protect_latch.sv
module drive_protect_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic cycle_start,
  input  logic set_all_off,
  input  logic set_ov,
  output logic force_all_off,
  output logic force_gate_off_clamp_on
);
  logic all_q, ov_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      all_q <= 1'b0;
      ov_q  <= 1'b0;
    end else begin
      all_q <= (cycle_start ? 1'b0 : all_q) | set_all_off;
      ov_q  <= (cycle_start ? 1'b0 : ov_q)  | set_ov;
    end
  end

  assign force_all_off           = all_q;
  assign force_gate_off_clamp_on = ov_q & ~all_q;
endmodule

// File: rtl/drive_fault_mgr.sv
module drive_fault_mgr
  import drive_fault_pkg::*;
#(
  parameter int OC_FILT  = 500,
  parameter int SAT_FILT = 2000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            oc_raw,
  input  logic            gate_sat_raw,
  input  logic            clamp_sat_raw,
  input  logic            ov_raw,
  input  logic            en_in,
  input  logic            ctl_in,
  input  logic            gate_on,
  input  logic            clamp_on,
  input  logic            loop_toggle,
  input  logic            ov_protect_en,
  input  logic            cs_n,
  input  logic            cs_rise,
  output logic [NFLT-1:0] fault_vec,
  output logic            fault_n,
  output logic            force_all_off,
  output logic            force_gate_off_clamp_on
);
  localparam int NSAT = 2;

  logic            active;
  logic            oc_hit;
  logic [NSAT-1:0] sat_qual, sat_hit;
  logic            cycle_start, open_evt;
  logic            ov_live, prio_evt, set_all;
  fault_word_t     evt;
  logic            flag;

  assign active = en_in & ctl_in;

  fault_persist_filter #(.LEN(OC_FILT)) u_oc_filt (
    .clk(clk), .rst_n(rst_n), .raw(oc_raw), .hit(oc_hit)
  );

  // index 0: gate switch, index 1: clamp switch
  assign sat_qual[0] = gate_sat_raw  & gate_on  & active;
  assign sat_qual[1] = clamp_sat_raw & clamp_on & active;

  for (genvar g = 0; g < NSAT; g++) begin : g_sat
    fault_persist_filter #(.LEN(SAT_FILT)) u_sat_filt (
      .clk(clk), .rst_n(rst_n), .raw(sat_qual[g]), .hit(sat_hit[g])
    );
  end

  cycle_tracker u_cyc (
    .clk(clk), .rst_n(rst_n), .active(active), .loop_toggle(loop_toggle),
    .cycle_start(cycle_start), .open_evt(open_evt)
  );

  always_comb begin
    evt           = '0;
    evt[BIT_OC]   = oc_hit;
    evt[BIT_OPEN] = open_evt;
    evt[BIT_CSAT] = sat_hit[1];
    evt[BIT_GSAT] = sat_hit[0];
    evt[BIT_OV]   = ov_raw;
  end

  assign ov_live  = ov_raw & ov_protect_en & active;
  assign prio_evt = oc_hit | (|sat_hit) | ov_live;
  assign set_all  = (oc_hit & active) | (|sat_hit);

  fault_report_latch u_rep (
    .clk(clk), .rst_n(rst_n), .evt(evt), .prio_evt(prio_evt),
    .flag_evt(prio_evt), .clr(cs_rise), .cs_n(cs_n),
    .cap_vec(fault_vec), .flag(flag)
  );

  assign fault_n = ~flag;

  drive_protect_latch u_prot (
    .clk(clk), .rst_n(rst_n), .cycle_start(cycle_start),
    .set_all_off(set_all), .set_ov(ov_live),
    .force_all_off(force_all_off),
    .force_gate_off_clamp_on(force_gate_off_clamp_on)
  );
endmodule

// File: rtl/drive_fault_mgr_chk.sv
module drive_fault_mgr_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       en_in,
  input logic       ctl_in,
  input logic       cs_n,
  input logic       cs_rise,
  input logic [4:0] fault_vec,
  input logic       fault_n,
  input logic       force_all_off,
  input logic       force_gate_off_clamp_on
);
  a_r11_capture_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |=> $stable(fault_vec));

  a_r3_shutdown_raises_alarm: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(force_all_off) |-> !fault_n);

  a_r8_ov_protect_raises_alarm: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(force_gate_off_clamp_on) && !$past(force_all_off) |-> !fault_n);

  a_r9_release_on_cycle_start: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(force_all_off) |-> $past(en_in && ctl_in));

  a_r10_alarm_clears_by_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_n) |-> $past(cs_rise));

  a_r14_force_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(force_all_off && force_gate_off_clamp_on));
endmodule

bind drive_fault_mgr drive_fault_mgr_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en_in(en_in), .ctl_in(ctl_in),
  .cs_n(cs_n), .cs_rise(cs_rise), .fault_vec(fault_vec),
  .fault_n(fault_n), .force_all_off(force_all_off),
  .force_gate_off_clamp_on(force_gate_off_clamp_on)
);

// File: tb/drive_fault_mgr_test.sv
`timescale 1ns/1ps
module drive_fault_mgr_test;
  localparam int OCF = 4;
  localparam int SATF = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic oc_raw = 0, gate_sat_raw = 0, clamp_sat_raw = 0, ov_raw = 0;
  logic en_in = 0, ctl_in = 0, gate_on = 0, clamp_on = 0, loop_toggle = 0;
  logic ov_protect_en = 0, cs_n = 1, cs_rise = 0;
  logic [4:0] fault_vec;
  logic fault_n, force_all_off, force_gate_off_clamp_on;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  drive_fault_mgr #(.OC_FILT(OCF), .SAT_FILT(SATF)) uut (
    .clk(clk), .rst_n(rst_n), .oc_raw(oc_raw), .gate_sat_raw(gate_sat_raw),
    .clamp_sat_raw(clamp_sat_raw), .ov_raw(ov_raw), .en_in(en_in),
    .ctl_in(ctl_in), .gate_on(gate_on), .clamp_on(clamp_on),
    .loop_toggle(loop_toggle), .ov_protect_en(ov_protect_en), .cs_n(cs_n),
    .cs_rise(cs_rise), .fault_vec(fault_vec), .fault_n(fault_n),
    .force_all_off(force_all_off),
    .force_gate_off_clamp_on(force_gate_off_clamp_on)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 0; oc_raw = 0; gate_sat_raw = 0; clamp_sat_raw = 0; ov_raw = 0;
    en_in = 0; ctl_in = 0; gate_on = 0; clamp_on = 0; loop_toggle = 0;
    ov_protect_en = 0; cs_n = 1; cs_rise = 0;
    step(2);
    rst_n = 1;
    step(1);
  endtask

  task automatic strobe_clear();
    cs_rise = 1; step(1); cs_rise = 0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R13 vec", fault_vec, 0);
    chk("R13 alarm", fault_n, 1);
    chk("R13 forces", {force_all_off, force_gate_off_clamp_on}, 0);
  endtask

  task automatic t_oc_idle();
    do_reset();
    oc_raw = 1; step(OCF);
    chk("R2 not yet confirmed", fault_vec, 0);
    step(1);
    chk("R1 R2 oc bit0", fault_vec, 5'b00001);
    chk("R3 alarm idle", fault_n, 0);
    chk("R3 no shutdown idle", force_all_off, 0);
    oc_raw = 0; step(1);
    en_in = 1; ctl_in = 1; step(3); en_in = 0; step(2);
    chk("R10 kept over cycle", fault_vec, 5'b00001);
    chk("R10 alarm kept", fault_n, 0);
  endtask

  task automatic t_oc_short();
    do_reset();
    oc_raw = 1; step(OCF - 1); oc_raw = 0; step(4);
    chk("R2 short pulse vec", fault_vec, 0);
    chk("R2 short pulse alarm", fault_n, 1);
  endtask

  task automatic t_oc_active_release();
    do_reset();
    en_in = 1; ctl_in = 1; step(2);
    oc_raw = 1; step(OCF + 1);
    chk("R3 shutdown active", force_all_off, 1);
    chk("R3 alarm active", fault_n, 0);
    oc_raw = 0; step(1);
    strobe_clear();
    chk("R10 cleared vec", fault_vec, 0);
    chk("R10 cleared alarm", fault_n, 1);
    chk("R9 strobe keeps shutdown", force_all_off, 1);
    en_in = 0; step(1); en_in = 1; step(1);
    chk("R9 released at cycle start", force_all_off, 0);
  endtask

  task automatic t_gate_sat();
    do_reset();
    en_in = 1; ctl_in = 1; gate_sat_raw = 1; step(20);
    chk("R4 gate off ignored", fault_vec, 0);
    gate_on = 1; step(SATF);
    chk("R4 gate not yet", fault_vec, 0);
    step(1);
    chk("R1 R4 gate bit3", fault_vec, 5'b01000);
    chk("R4 gate shutdown", force_all_off, 1);
    chk("R4 gate alarm", fault_n, 0);
  endtask

  task automatic t_clamp_sat();
    do_reset();
    clamp_on = 1; clamp_sat_raw = 1; step(20);
    chk("R4 clamp idle ignored", fault_vec, 0);
    en_in = 1; ctl_in = 1; step(SATF + 1);
    chk("R1 R4 clamp bit2", fault_vec, 5'b00100);
    chk("R4 clamp shutdown", force_all_off, 1);
  endtask

  task automatic t_lockout();
    do_reset();
    en_in = 1; ctl_in = 1; step(2);
    oc_raw = 1; step(OCF + 1); oc_raw = 0;
    gate_on = 1; gate_sat_raw = 1; step(SATF + 3);
    chk("R5 later fault locked out", fault_vec, 5'b00001);
  endtask

  task automatic t_same_cycle_clear();
    do_reset();
    oc_raw = 1; step(OCF + 1);
    strobe_clear();
    chk("R12 fault kept over clear", fault_vec, 5'b00001);
    chk("R12 alarm kept over clear", fault_n, 0);
    oc_raw = 0; step(1);
    strobe_clear();
    chk("R10 clear after removal", fault_vec, 0);
    chk("R10 alarm released", fault_n, 1);
  endtask

  task automatic t_open_load();
    do_reset();
    en_in = 1; ctl_in = 1; step(5); ctl_in = 0; step(1);
    chk("R1 R6 open bit1", fault_vec, 5'b00010);
    chk("R6 no alarm", fault_n, 1);
    do_reset();
    en_in = 1; ctl_in = 1; step(2);
    loop_toggle = 1; step(1); loop_toggle = 0; step(2);
    ctl_in = 0; step(2);
    chk("R6 healthy cycle", fault_vec, 0);
  endtask

  task automatic t_ov_report();
    do_reset();
    en_in = 1; ctl_in = 1; step(1);
    ov_raw = 1; step(1);
    chk("R1 R7 ov bit4", fault_vec, 5'b10000);
    chk("R7 no alarm", fault_n, 1);
    chk("R7 no forces", {force_all_off, force_gate_off_clamp_on}, 0);
  endtask

  task automatic t_ov_protect();
    do_reset();
    ov_protect_en = 1; en_in = 1; ctl_in = 1; step(2);
    ov_raw = 1; step(1);
    chk("R8 ov bit", fault_vec, 5'b10000);
    chk("R8 alarm", fault_n, 0);
    chk("R8 gate off clamp on", force_gate_off_clamp_on, 1);
    chk("R8 no full shutdown", force_all_off, 0);
    oc_raw = 1; step(OCF + 1);
    chk("R8 ov priority locks oc", fault_vec, 5'b10000);
    chk("R14 shutdown wins", {force_all_off, force_gate_off_clamp_on}, 2'b10);
  endtask

  task automatic t_cs_hold();
    do_reset();
    cs_n = 0; oc_raw = 1; step(OCF + 3);
    chk("R11 frozen in frame", fault_vec, 0);
    cs_n = 1; step(1);
    chk("R11 updated after frame", fault_vec, 5'b00001);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_oc_idle();
    t_oc_short();
    t_oc_active_release();
    t_gate_sat();
    t_clamp_sat();
    t_lockout();
    t_same_cycle_clear();
    t_open_load();
    t_ov_report();
    t_ov_protect();
    t_cs_hold();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule